// File: doc/BRIEF.md
# Three-Stage RV32I Subset Integer Core

This block is a small in-order 32-bit integer core with three stages. The first stage fetches an instruction word and decodes it. The second stage reads the register file, picks the ALU operands, computes the result and resolves branches and jumps. The third stage writes the register file, or drives a store to data memory. One instruction enters per cycle. A taken branch or a jump costs one flushed slot. There are no stalls.

The supported instructions are ADD, SUB, XOR, OR, AND, ADDI, XORI, ANDI, SRAI, LUI, LW, SW, BEQ, BNE and JAL.

Both memory ports use a combinational read. The instruction word must match `imemAddr` within the same cycle. The load word must match `dmemAddr` within the same cycle. A store is written on the clock edge that ends its writeback cycle. A word whose opcode field is all ones stops the core, so a surrounding environment can detect the end of a program.

Top module: `rv3_core`

## Requirements
- R1: While `rstN` is low, the fetch address becomes RESET_PC (default 0), `dmemWe` stays low and `halt` stays low. No instruction is in flight when reset is released.
- R2: When there is no redirect and no halt, the fetch address advances by 4 every cycle. The address sequence equals the executed program order, with one wrong-path fetch at PC+4 after each redirect.
- R3: The first ALU operand is always the rs1 value. The second operand is the sign-extended immediate for ADDI, XORI, ANDI, SRAI, LUI, LW and SW, and the rs2 value otherwise. LUI writes its upper-20-bit immediate followed by twelve zero bits.
- R4: When the writeback stage writes register rd and the execute stage reads rd as rs1 or rs2, the writeback value (ALU result or load data) replaces the stale operand in that same cycle.
- R5: Register x0 reads as zero. A write that targets x0 has no effect, and it is never forwarded.
- R6: LW and SW form their address as rs1 plus the sign-extended immediate (I-type for loads, S-type with bits [31:25] and [11:7] for stores). A store drives address, rs2 data and `dmemWe` during its writeback cycle and writes no register.
- R7: Branches compare with a 33-bit subtraction {a[31],a} − {b[31],b}. BEQ (funct3 000) is taken on a zero result. BNE (funct3 001) is taken on a nonzero result.
- R8: A taken branch or a JAL sends the next fetch to the execute-stage PC plus its immediate. The one instruction already fetched behind it becomes a bubble. JAL writes its own PC+4 to rd.
- R9: Decoding uses the standard fields: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25]. Opcodes are 0110011 (register ALU), 0010011 (immediate ALU), 0000011 (LW, funct3 010), 0100011 (SW, funct3 010), 1100011 (branch), 0110111 (LUI) and 1101111 (JAL). Register ALU funct3 is 000 (ADD, or SUB when funct7 is 0100000), 100 XOR, 110 OR and 111 AND. Immediate ALU funct3 is 000 ADDI, 100 XORI, 111 ANDI, and 101 with funct7 0100000 for SRAI. The word 0x00e7c7b3 is xor x15,x15,x14. Any other word is a bubble.
- R10: A word with opcode 1111111 raises `halt` when it reaches execute. `halt` then stays high, the fetch address freezes, and no later instruction stores or writes a register.
- R11: A Hamming-distance loop over the operands 1 and 4 stores the distance 2.
- R12: `halt` first rises exactly one cycle after the halting word is fetched. The total cycle count equals the number of instructions executed, plus one per redirect, plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| imemAddr | output | 32 | Fetch address (byte address, word aligned) |
| imemData | input | 32 | Instruction word at imemAddr, same cycle |
| dmemAddr | output | 32 | Data address of the instruction in writeback |
| dmemWe | output | 1 | Store strobe, written at the next rising edge |
| dmemWdata | output | 32 | Store data |
| dmemRdata | input | 32 | Load word at dmemAddr, same cycle |
| halt | output | 1 | Sticky stop indication |

## Verification
The program is built in three parts. A Hamming loop exercises load-to-use forwarding, loop-back BNE and skip-forward BEQ, and its taken/not-taken mix makes any error in flush or target arithmetic show in the fetch trace. A chain of dependent ALU instructions stores every result; it separates immediate from register operand selection, SUB from ADD, and the sign fill of SRAI and of negative immediates. Short targeted sequences then cover the remaining cases:
- an x0 write followed at once by a read of x0;
- a BNE on 0x80000000 against zero;
- a JAL whose shadow instruction must vanish;
- the literal word 0x00e7c7b3 feeding a dependent store.

Fetch addresses and stores are compared against a behavioural instruction model in every cycle.

// File: rtl/rv3_pkg.sv
package rv3_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_XOR, ALU_AND, ALU_OR, ALU_SRA, ALU_PASS
  } aluOpE;

  typedef enum logic [2:0] {
    IMM_I, IMM_S, IMM_B, IMM_U, IMM_J
  } immKindE;

  // strobes handed from decode to the datapath
  typedef struct packed {
    logic    valid;
    logic    useImm;
    aluOpE   aluOp;
    immKindE immKind;
    logic    regWe;
    logic    memRd;
    logic    memWr;
    logic    isBeq;
    logic    isBne;
    logic    isJal;
    logic    isHalt;
  } ctrlS;
endpackage

// File: rtl/rv3_regfile.sv
module rv3_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  output logic [DW-1:0] rdDataA,
  input  logic [AW-1:0] rdAddrB,
  output logic [DW-1:0] rdDataB,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wAddr != '0)) begin
      regs[wAddr] <= wData;
    end
  end

  // register zero is hard-wired
  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/rv3_ctrl.sv
module rv3_ctrl
  import rv3_pkg::*;
#(
  parameter logic [6:0] HALT_OPC = 7'b1111111
) (
  input  logic [6:0] opc,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrlS       ctrl
);
  always_comb begin
    ctrl = '0;
    if (opc == HALT_OPC) begin
      ctrl.valid  = 1'b1;
      ctrl.isHalt = 1'b1;
    end else begin
      unique case (opc)
        OPC_REG: begin
          ctrl.valid = 1'b1;
          ctrl.regWe = 1'b1;
          case (funct3)
            3'b000: begin
              if (funct7 == 7'b0100000)      ctrl.aluOp = ALU_SUB;
              else if (funct7 == 7'b0000000) ctrl.aluOp = ALU_ADD;
              else                           ctrl.valid = 1'b0;
            end
            3'b100:  ctrl.aluOp = ALU_XOR;
            3'b110:  ctrl.aluOp = ALU_OR;
            3'b111:  ctrl.aluOp = ALU_AND;
            default: ctrl.valid = 1'b0;
          endcase
        end
        OPC_IMM: begin
          ctrl.valid   = 1'b1;
          ctrl.regWe   = 1'b1;
          ctrl.useImm  = 1'b1;
          ctrl.immKind = IMM_I;
          case (funct3)
            3'b000:  ctrl.aluOp = ALU_ADD;
            3'b100:  ctrl.aluOp = ALU_XOR;
            3'b111:  ctrl.aluOp = ALU_AND;
            3'b101: begin
              if (funct7 == 7'b0100000) ctrl.aluOp = ALU_SRA;
              else                      ctrl.valid = 1'b0;
            end
            default: ctrl.valid = 1'b0;
          endcase
        end
        OPC_LOAD: begin
          ctrl.valid   = (funct3 == 3'b010);
          ctrl.regWe   = 1'b1;
          ctrl.memRd   = 1'b1;
          ctrl.useImm  = 1'b1;
          ctrl.immKind = IMM_I;
          ctrl.aluOp   = ALU_ADD;
        end
        OPC_STORE: begin
          ctrl.valid   = (funct3 == 3'b010);
          ctrl.memWr   = 1'b1;
          ctrl.useImm  = 1'b1;
          ctrl.immKind = IMM_S;
          ctrl.aluOp   = ALU_ADD;
        end
        OPC_BRANCH: begin
          ctrl.valid   = (funct3 == 3'b000) || (funct3 == 3'b001);
          ctrl.isBeq   = (funct3 == 3'b000);
          ctrl.isBne   = (funct3 == 3'b001);
          ctrl.immKind = IMM_B;
        end
        OPC_LUI: begin
          ctrl.valid   = 1'b1;
          ctrl.regWe   = 1'b1;
          ctrl.useImm  = 1'b1;
          ctrl.immKind = IMM_U;
          ctrl.aluOp   = ALU_PASS;
        end
        OPC_JAL: begin
          ctrl.valid   = 1'b1;
          ctrl.regWe   = 1'b1;
          ctrl.isJal   = 1'b1;
          ctrl.immKind = IMM_J;
        end
        default: ctrl.valid = 1'b0;
      endcase
    end
    // an undecodable word travels as a bubble
    if (!ctrl.valid) ctrl = '0;
  end
endmodule

// File: rtl/rv3_datapath.sv
module rv3_datapath
  import rv3_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlS            fdCtrl,
  input  logic [31:7]     fdBody,
  input  logic [XLEN-1:0] dmemRdata,
  output logic [XLEN-1:0] imemAddr,
  output logic [XLEN-1:0] dmemAddr,
  output logic            dmemWe,
  output logic [XLEN-1:0] dmemWdata,
  output logic            halt,
  output logic            redirect,
  output logic            exValid,
  output logic            rfWe
);
  localparam logic [XLEN-1:0] INST_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] immGen(input logic [31:7] w, input immKindE k);
    case (k)
      IMM_I:   return {{20{w[31]}}, w[31:20]};
      IMM_S:   return {{20{w[31]}}, w[31:25], w[11:7]};
      IMM_B:   return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
      IMM_U:   return {w[31:12], 12'b0};
      IMM_J:   return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      default: return '0;
    endcase
  endfunction

  // fetch state
  logic [XLEN-1:0] fetchPc, nextPc;
  logic            haltQ;

  // execute stage registers
  ctrlS            exCtrl;
  logic [31:7]     exBody;
  logic [XLEN-1:0] exPc;

  // writeback stage registers
  logic              wbRegWe, wbMemRd, wbMemWr;
  logic [REG_AW-1:0] wbRd;
  logic [XLEN-1:0]   wbResult, wbStore, wbData;

  // execute combinational
  logic [REG_AW-1:0] exRs1, exRs2, exRd;
  logic [XLEN-1:0]   exImm, rfA, rfB, op1, op2, aluB, aluOut, exResult, target;
  logic [XLEN:0]     cmpDiff;
  logic              brTaken;

  assign exRs1 = exBody[19:15];
  assign exRs2 = exBody[24:20];
  assign exRd  = exBody[11:7];
  assign exImm = immGen(exBody, exCtrl.immKind);

  rv3_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (exRs1),
    .rdDataA (rfA),
    .rdAddrB (exRs2),
    .rdDataB (rfB),
    .we      (rfWe),
    .wAddr   (wbRd),
    .wData   (wbData)
  );

  // writeback value and register write strobe
  assign wbData = wbMemRd ? dmemRdata : wbResult;
  assign rfWe   = wbRegWe && (wbRd != '0);

  // writeback-to-execute bypass
  assign op1  = (rfWe && (wbRd == exRs1)) ? wbData : rfA;
  assign op2  = (rfWe && (wbRd == exRs2)) ? wbData : rfB;
  assign aluB = exCtrl.useImm ? exImm : op2;

  always_comb begin
    case (exCtrl.aluOp)
      ALU_ADD:  aluOut = op1 + aluB;
      ALU_SUB:  aluOut = op1 - aluB;
      ALU_XOR:  aluOut = op1 ^ aluB;
      ALU_AND:  aluOut = op1 & aluB;
      ALU_OR:   aluOut = op1 | aluB;
      ALU_SRA:  aluOut = $unsigned($signed(op1) >>> aluB[4:0]);
      ALU_PASS: aluOut = aluB;
      default:  aluOut = '0;
    endcase
  end

  // branch compare on one extra sign bit
  assign cmpDiff  = {op1[XLEN-1], op1} - {op2[XLEN-1], op2};
  assign brTaken  = (exCtrl.isBeq && (cmpDiff == '0)) || (exCtrl.isBne && (cmpDiff != '0));
  assign redirect = brTaken || exCtrl.isJal;
  assign target   = exPc + exImm;
  assign exResult = exCtrl.isJal ? (exPc + INST_BYTES) : aluOut;

  assign halt     = haltQ || exCtrl.isHalt;
  assign exValid  = exCtrl.valid;

  always_comb begin
    if (halt)          nextPc = fetchPc;
    else if (redirect) nextPc = target;
    else               nextPc = fetchPc + INST_BYTES;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc  <= RESET_PC;
      haltQ    <= 1'b0;
      exCtrl   <= '0;
      exBody   <= '0;
      exPc     <= '0;
      wbRegWe  <= 1'b0;
      wbMemRd  <= 1'b0;
      wbMemWr  <= 1'b0;
      wbRd     <= '0;
      wbResult <= '0;
      wbStore  <= '0;
    end else begin
      fetchPc  <= nextPc;
      haltQ    <= halt;
      exCtrl   <= (redirect || halt) ? '0 : fdCtrl;
      exBody   <= fdBody;
      exPc     <= fetchPc;
      wbRegWe  <= exCtrl.regWe;
      wbMemRd  <= exCtrl.memRd;
      wbMemWr  <= exCtrl.memWr;
      wbRd     <= exRd;
      wbResult <= exResult;
      wbStore  <= op2;
    end
  end

  assign imemAddr  = fetchPc;
  assign dmemAddr  = wbResult;
  assign dmemWe    = wbMemWr;
  assign dmemWdata = wbStore;
endmodule

// File: rtl/rv3_core.sv
module rv3_core
  import rv3_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [6:0]      HALT_OPC = 7'b1111111
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] imemAddr,
  input  logic [31:0]     imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic            dmemWe,
  output logic [XLEN-1:0] dmemWdata,
  input  logic [XLEN-1:0] dmemRdata,
  output logic            halt
);
  ctrlS fdCtrl;
  logic redirect, exValid, rfWe;

  rv3_ctrl #(.HALT_OPC(HALT_OPC)) u_ctrl (
    .opc    (imemData[6:0]),
    .funct3 (imemData[14:12]),
    .funct7 (imemData[31:25]),
    .ctrl   (fdCtrl)
  );

  rv3_datapath #(.RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fdCtrl    (fdCtrl),
    .fdBody    (imemData[31:7]),
    .dmemRdata (dmemRdata),
    .imemAddr  (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWe    (dmemWe),
    .dmemWdata (dmemWdata),
    .halt      (halt),
    .redirect  (redirect),
    .exValid   (exValid),
    .rfWe      (rfWe)
  );
endmodule

// File: rtl/rv3_core_chk.sv
module rv3_core_chk #(
  parameter logic [31:0] RST_PC = '0
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] imemAddr,
  input logic        dmemWe,
  input logic        halt,
  input logic        redirect,
  input logic        exValid,
  input logic        rfWe
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (imemAddr == RST_PC && !dmemWe && !halt)); // R1

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (!redirect && !halt) |=> (imemAddr == $past(imemAddr) + 32'd4)); // R2

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !exValid); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (halt && $stable(imemAddr))); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (halt && $past(halt)) |-> (!dmemWe && !rfWe)); // R10

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |-> !rfWe); // R6
endmodule

bind rv3_core rv3_core_chk #(.RST_PC(RESET_PC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .imemAddr (imemAddr),
  .dmemWe   (dmemWe),
  .halt     (halt),
  .redirect (redirect),
  .exValid  (exValid),
  .rfWe     (rfWe)
);

// File: tb/tb_rv3_core.sv
module tb_rv3_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe, halt;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  // reference model state
  logic [31:0] rf [32];
  logic [31:0] refMem [64];
  logic [31:0] fq [$];
  logic [63:0] sq [$];

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  rv3_core dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWe(dmemWe), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata), .halt(halt)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (dmemWe) dmem[dmemAddr[7:2]] <= dmemWdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // encoders
  function automatic logic [31:0] eI(input logic [6:0] op, input logic [2:0] f3, input int rd, input int rs1, input int imm);
    logic [31:0] v = imm;
    return {v[11:0], 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] eR(input logic [6:0] f7, input logic [2:0] f3, input int rd, input int rs1, input int rs2);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] eS(input int rs2, input int rs1, input int imm);
    logic [31:0] v = imm;
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] eB(input logic [2:0] f3, input int rs1, input int rs2, input int imm);
    logic [31:0] v = imm;
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'h63};
  endfunction
  function automatic logic [31:0] eU(input int rd, input logic [19:0] up);
    return {up, 5'(rd), 7'h37};
  endfunction
  function automatic logic [31:0] eJ(input int rd, input int imm);
    logic [31:0] v = imm;
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'h6f};
  endfunction

  task automatic buildProgram();
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; refMem[i] = '0; end
    imem[0]  = eI(7'h13, 3'b000, 2, 0, 64);
    imem[1]  = eI(7'h13, 3'b000, 5, 0, 1);
    imem[2]  = eI(7'h13, 3'b000, 6, 0, 4);
    imem[3]  = eS(5, 2, 0);
    imem[4]  = eS(6, 2, 4);
    imem[5]  = eI(7'h03, 3'b010, 7, 2, 0);
    imem[6]  = eI(7'h03, 3'b010, 8, 2, 4);
    imem[7]  = eR(7'h00, 3'b100, 9, 7, 8);      // load data forwarded (R4)
    imem[8]  = eI(7'h13, 3'b000, 10, 0, 0);
    imem[9]  = eB(3'b000, 9, 0, 24);            // 0x24 -> 0x3c
    imem[10] = eI(7'h13, 3'b111, 11, 9, 1);     // 0x28
    imem[11] = eB(3'b000, 11, 0, 8);            // 0x2c -> 0x34
    imem[12] = eI(7'h13, 3'b000, 10, 10, 1);
    imem[13] = eI(7'h13, 3'b101, 9, 9, 32'h401); // srai by 1
    imem[14] = eB(3'b001, 9, 0, -16);           // 0x38 -> 0x28
    imem[15] = eS(10, 2, 8);                    // hamming -> word 18
    imem[16] = eR(7'h00, 3'b000, 12, 5, 6);
    imem[17] = eR(7'h20, 3'b000, 13, 5, 6);
    imem[18] = eR(7'h00, 3'b110, 14, 12, 13);
    imem[19] = eR(7'h00, 3'b111, 15, 13, 6);
    imem[20] = eI(7'h13, 3'b100, 16, 13, -1);
    imem[21] = eU(17, 20'h12345);
    imem[22] = eR(7'h20, 3'b000, 18, 17, 13);
    imem[23] = eS(12, 2, 12);
    imem[24] = eS(13, 2, 16);
    imem[25] = eS(14, 2, 20);
    imem[26] = eS(15, 2, 24);
    imem[27] = eS(16, 2, 28);
    imem[28] = eS(17, 2, 32);                   // word 24
    imem[29] = eS(18, 2, 36);
    imem[30] = eI(7'h13, 3'b000, 0, 0, 7);      // write to x0
    imem[31] = eR(7'h00, 3'b000, 19, 0, 5);
    imem[32] = eS(19, 2, 40);                   // word 26
    imem[33] = eU(20, 20'h80000);
    imem[34] = eB(3'b001, 20, 0, 8);            // 0x88 -> 0x90
    imem[35] = eI(7'h13, 3'b000, 21, 0, 99);    // shadow, flushed
    imem[36] = eS(21, 2, 44);                   // word 27
    imem[37] = eJ(1, 8);                        // 0x94 -> 0x9c
    imem[38] = eI(7'h13, 3'b000, 22, 0, 55);    // shadow, flushed
    imem[39] = eS(1, 2, 48);                    // word 28
    imem[40] = eS(22, 2, 52);                   // word 29
    imem[41] = 32'h00e7c7b3;                    // xor x15,x15,x14
    imem[42] = eS(15, 2, 56);                   // word 30
    imem[43] = 32'hffffffff;
  endtask

  task automatic runModel();
    logic [31:0] pc, ins, a, b, nx, ii, ad;
    logic [2:0]  f3;
    int rd, rs1, rs2;
    bit taken;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    pc = '0;
    for (int s = 0; s < 1000; s++) begin
      ins = imem[pc[7:2]];
      fq.push_back(pc);
      if (ins[6:0] == 7'h7f) break;
      rd = ins[11:7]; rs1 = ins[19:15]; rs2 = ins[24:20]; f3 = ins[14:12];
      a = rf[rs1]; b = rf[rs2]; nx = pc + 4;
      ii = {{20{ins[31]}}, ins[31:20]};
      case (ins[6:0])
        7'h33: case (f3)
                 3'd0: rf[rd] = ins[30] ? a - b : a + b;
                 3'd4: rf[rd] = a ^ b;
                 3'd6: rf[rd] = a | b;
                 3'd7: rf[rd] = a & b;
                 default: ;
               endcase
        7'h13: case (f3)
                 3'd0: rf[rd] = a + ii;
                 3'd4: rf[rd] = a ^ ii;
                 3'd7: rf[rd] = a & ii;
                 3'd5: rf[rd] = $signed(a) >>> ins[24:20];
                 default: ;
               endcase
        7'h03: begin ad = a + ii; rf[rd] = refMem[ad[7:2]]; end
        7'h23: begin
                 ad = a + {{20{ins[31]}}, ins[31:25], ins[11:7]};
                 refMem[ad[7:2]] = b;
                 sq.push_back({ad, b});
               end
        7'h63: begin
                 taken = (f3 == 3'd0) ? (a == b) : (a != b);
                 if (taken) begin
                   fq.push_back(pc + 4);
                   nx = pc + {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
                 end
               end
        7'h37: rf[rd] = {ins[31:12], 12'b0};
        7'h6f: begin
                 rf[rd] = pc + 4;
                 fq.push_back(pc + 4);
                 nx = pc + {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
               end
        default: ;
      endcase
      rf[0] = '0;
      pc = nx;
    end
  endtask

  initial begin
    int k;
    int expCycles;
    bit done;
    logic [63:0] st;
    buildProgram();
    runModel();
    expCycles = fq.size();

    repeat (3) begin
      @(negedge clk);
      chk(imemAddr == 32'h0, "R1 reset fetch address", imemAddr, 32'h0);
      chk(!dmemWe && !halt, "R1 reset strobes", {30'b0, dmemWe, halt}, 32'h0);
    end
    rstN = 1'b1;

    k = 0;
    done = 1'b0;
    while (!done && k < 4000) begin
      #1;
      if (k < fq.size())
        chk(imemAddr == fq[k], "R2 fetch address", imemAddr, fq[k]);
      if (dmemWe) begin
        if (sq.size() == 0) begin
          chk(1'b0, "R6 unexpected store", dmemAddr, 32'h0);
        end else begin
          st = sq.pop_front();
          chk(dmemAddr == st[63:32], "R6 store address", dmemAddr, st[63:32]);
          chk(dmemWdata == st[31:0], "R4 store data", dmemWdata, st[31:0]);
        end
      end
      chk(halt == (k >= expCycles), "R10 halt level", {31'b0, halt}, {31'b0, k >= expCycles});
      if (halt) begin
        chk(k == expCycles, "R12 cycle count", k, expCycles);
        done = 1'b1;
      end
      @(negedge clk);
      k++;
    end
    if (!done) chk(1'b0, "R12 watchdog expired", k, expCycles);

    for (int c = 0; c < 5; c++) begin
      #1;
      chk(halt && !dmemWe, "R10 quiet after halt", {30'b0, halt, dmemWe}, 32'h2);
      @(negedge clk);
    end
    chk(sq.size() == 0, "R6 all stores seen", sq.size(), 0);

    chk(dmem[18] == 32'd2, "R11 hamming distance", dmem[18], 32'd2);
    chk(dmem[19] == 32'd5, "R3 register add", dmem[19], 32'd5);
    chk(dmem[20] == 32'hfffffffd, "R3 register sub", dmem[20], 32'hfffffffd);
    chk(dmem[23] == 32'd2, "R3 xori sign-extended", dmem[23], 32'd2);
    chk(dmem[24] == 32'h12345000, "R3 lui", dmem[24], 32'h12345000);
    chk(dmem[26] == 32'd1, "R5 x0 write dropped", dmem[26], 32'd1);
    chk(dmem[27] == 32'd0, "R8 branch shadow flushed", dmem[27], 32'd0);
    chk(dmem[28] == 32'h98, "R8 jal link", dmem[28], 32'h98);
    chk(dmem[29] == 32'd0, "R8 jal shadow flushed", dmem[29], 32'd0);
    chk(dmem[30] == 32'hfffffff9, "R9 literal xor decode", dmem[30], 32'hfffffff9);
    for (int i = 0; i < 64; i++)
      chk(dmem[i] == refMem[i], "R6 memory image", dmem[i], refMem[i]);
    chk(dmem[16] == 32'd1 && dmem[17] == 32'd4, "R7 loop operands", dmem[16], 32'd1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule